// File: doc/BRIEF.md
# Serial Interrupt Peripheral Frame Engine

This block is the device end of a shared, single-wire serial interrupt channel. It watches a small set of local interrupt lines and tracks the host's serial cycle. That cycle is a start pulse, a fixed train of three-clock data frames and a stop pulse. In the Sample clock of each frame that it owns, the block reports the level of the line mapped to that frame. A per-line frame code maps each line to a frame. Any code at or above the frame count disables that line.

In Quiet mode the block starts a cycle by itself when a line's level differs from the level it last reported. It does this only when the wire is idle. In Continuous mode it waits for the host to start every cycle. The width of the host's stop pulse selects the mode for the next cycle. The wire is modelled as an input value plus an output enable and an output value. The bench forms the wired-AND.

The state machine has these states:

| State | Meaning |
|---|---|
| ST_IDLE | No cycle is running. |
| ST_KICK | The block drives its own one-clock start low. |
| ST_START_LO | The start pulse is low. |
| ST_START_TA | Turn-around after the start pulse. |
| ST_DATA | Data frames. A phase counter runs Sample, Recover, Turn. |
| ST_STOP_WAIT | Idle clocks before the stop pulse. |
| ST_STOP_LO | The stop pulse is low and its clocks are counted. |
| ST_STOP_TA | Turn-around after the stop pulse. |

The transitions are:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_START_LO | The wire is seen low. This has priority. |
| ST_IDLE | ST_KICK | Quiet mode and a change is pending. |
| ST_KICK | ST_START_LO | Always. |
| ST_START_LO | ST_START_TA | The wire is seen high. That clock is the host's recovery clock. |
| ST_START_TA | ST_DATA | Always. The frame number is set to 0 and the phase to Sample. |
| ST_DATA | ST_STOP_WAIT | After the Turn clock of the last frame. |
| ST_STOP_WAIT | ST_STOP_LO | The wire is seen low. |
| ST_STOP_LO | ST_STOP_TA | The wire is seen high. The mode is latched at this point. |
| ST_STOP_TA | ST_IDLE | Always. |

Top module: `sirq_frame_engine`

## Requirements
- R1: In Quiet mode, a pending change moves the block from idle to a start request. Suppose the change appears in clock c while the wire is high. Then in clock c+1 the block drives the wire low for exactly that one clock. It then releases the wire and never drives it high during the start pulse.
- R2: The block never begins a start while a cycle is active. Suppose a line changes after its own frame's Sample clock has passed. The change is then held. In Quiet mode it causes a start request in the second clock after the stop pulse's turn-around clock.
- R3: Suppose a line changes before or during its own frame's Sample clock in a running cycle. The new level is reported in that cycle, and no extra start request follows the stop.
- R4: After the start pulse come its recovery clock and its turn-around clock. Frame k's Sample clock then falls 3k clocks later, for k from 0 to 16 (17 frames). In that clock the block drives the wire low exactly when some enabled line mapped to frame k is low. Otherwise it leaves the wire released.
- R5: In a Recovery clock the block drives the wire high only if it drove it low in the Sample clock just before. In every Turn clock the block releases the wire.
- R6: Start pulses of any total low width from 4 to 8 clocks are tolerated. Frame counting starts from the first high clock that follows the pulse.
- R7: The block counts the low clocks of the stop pulse. A 2-clock pulse selects Quiet mode for the following time and a pulse of 3 or more clocks selects Continuous mode. Any number of idle high clocks may come before the pulse.
- R8: In Continuous mode the block never begins a start, even with changes pending.
- R9: Line i takes its frame code from `frame_cfg[i*5 +: 5]`. A code of 17 or more disables the line, so it is never driven and its changes never request a start.
- R10: After reset the block is idle and in Quiet mode with the wire released. Every line counts as last reported high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Local interrupt levels |
| frame_cfg | input | NUM_LINES*FRAME_W | Frame code per line, 5 bits each |
| sirq_in | input | 1 | Resolved level of the shared wire |
| sirq_oe | output | 1 | The block drives the wire |
| sirq_out | output | 1 | Value driven when sirq_oe is high |

## Verification
The risky coincidence is a line changing in the very clock of its own frame's Sample phase. In that clock the change tracker and the frame driver both act on the same level. The level must be delivered and must also clear the pending state, so that no spurious start follows the stop. The bench provokes this by toggling a line at the start of a chosen frame's Sample clock. The frame it chooses moves across runs, so it sometimes lands on the line's own frame, sometimes before it and sometimes after it. The bench judges the outcome by the wire level in that clock and by whether a start request appears two clocks after the stop. Both are predicted from a per-line model of the last reported level.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KICK,
        ST_START_LO,
        ST_START_TA,
        ST_DATA,
        ST_STOP_WAIT,
        ST_STOP_LO,
        ST_STOP_TA
    } sirq_state_t;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } sirq_phase_t;

endpackage

// File: rtl/sirq_slot_match.sv
module sirq_slot_match #(
    parameter int NUM_LINES  = 4,
    parameter int NUM_FRAMES = 17,
    parameter int FRAME_W    = 5
) (
    input  logic [NUM_LINES*FRAME_W-1:0] frame_cfg,
    input  logic [FRAME_W-1:0]           frame_idx,
    input  logic                         sample_en,
    input  logic [NUM_LINES-1:0]         irq_lines,
    output logic [NUM_LINES-1:0]         line_en,
    output logic [NUM_LINES-1:0]         line_hit,
    output logic                         own_low
);
    localparam logic [FRAME_W-1:0] CODE_LIMIT = FRAME_W'(NUM_FRAMES);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [FRAME_W-1:0] code;
        assign code        = frame_cfg[i*FRAME_W +: FRAME_W];
        assign line_en[i]  = (code < CODE_LIMIT);
        assign line_hit[i] = line_en[i] && sample_en && (code == frame_idx);
    end

    assign own_low = |(line_hit & ~irq_lines);

endmodule

// File: rtl/sirq_change_track.sv
module sirq_change_track #(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [NUM_LINES-1:0] line_hit,
    output logic                 any_pending
);
    logic [NUM_LINES-1:0] reported;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_rep
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reported[i] <= 1'b1;
            end else if (line_hit[i]) begin
                reported[i] <= irq_lines[i];
            end
        end
    end

    assign any_pending = |(line_en & (irq_lines ^ reported));

endmodule

// File: rtl/sirq_frame_engine.sv
module sirq_frame_engine
    import sirq_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int NUM_FRAMES = 17,
    parameter int FRAME_W    = $clog2(NUM_FRAMES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         irq_lines,
    input  logic [NUM_LINES*FRAME_W-1:0] frame_cfg,
    input  logic                         sirq_in,
    output logic                         sirq_oe,
    output logic                         sirq_out
);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

    sirq_state_t          state, state_nx;
    sirq_phase_t          phase;
    logic [FRAME_W-1:0]   frame_idx;
    logic [1:0]           stop_cnt;
    logic                 cont_mode;
    logic                 drove_low;
    logic                 sample_en;
    logic                 own_low;
    logic                 any_pending;
    logic [NUM_LINES-1:0] line_en;
    logic [NUM_LINES-1:0] line_hit;

    assign sample_en = (state == ST_DATA) && (phase == PH_SAMPLE);

    sirq_slot_match #(
        .NUM_LINES (NUM_LINES),
        .NUM_FRAMES(NUM_FRAMES),
        .FRAME_W   (FRAME_W)
    ) u_match (
        .frame_cfg(frame_cfg),
        .frame_idx(frame_idx),
        .sample_en(sample_en),
        .irq_lines(irq_lines),
        .line_en  (line_en),
        .line_hit (line_hit),
        .own_low  (own_low)
    );

    sirq_change_track #(
        .NUM_LINES(NUM_LINES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .line_en    (line_en),
        .line_hit   (line_hit),
        .any_pending(any_pending)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!sirq_in) begin
                    state_nx = ST_START_LO;
                end else if (!cont_mode && any_pending) begin
                    state_nx = ST_KICK;
                end
            end
            ST_KICK:      state_nx = ST_START_LO;
            ST_START_LO:  if (sirq_in) state_nx = ST_START_TA;
            ST_START_TA:  state_nx = ST_DATA;
            ST_DATA: begin
                if (phase == PH_TURN && frame_idx == LAST_FRAME) begin
                    state_nx = ST_STOP_WAIT;
                end
            end
            ST_STOP_WAIT: if (!sirq_in) state_nx = ST_STOP_LO;
            ST_STOP_LO:   if (sirq_in) state_nx = ST_STOP_TA;
            ST_STOP_TA:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Frame position, stop-width counter and mode latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_SAMPLE;
            frame_idx <= '0;
            stop_cnt  <= '0;
            cont_mode <= 1'b0;
            drove_low <= 1'b0;
        end else begin
            drove_low <= sample_en && own_low;
            if (state == ST_START_TA) begin
                phase     <= PH_SAMPLE;
                frame_idx <= '0;
            end else if (state == ST_DATA) begin
                unique case (phase)
                    PH_SAMPLE:  phase <= PH_RECOVER;
                    PH_RECOVER: phase <= PH_TURN;
                    default: begin
                        phase     <= PH_SAMPLE;
                        frame_idx <= frame_idx + 1'b1;
                    end
                endcase
            end
            if (state == ST_STOP_WAIT && !sirq_in) begin
                stop_cnt <= 2'd1;
            end else if (state == ST_STOP_LO) begin
                if (!sirq_in) begin
                    if (stop_cnt != 2'd3) stop_cnt <= stop_cnt + 1'b1;
                end else begin
                    cont_mode <= (stop_cnt == 2'd3);
                end
            end
        end
    end

    // Wire drive
    always_comb begin
        sirq_oe  = 1'b0;
        sirq_out = 1'b1;
        unique case (state)
            ST_KICK: begin
                sirq_oe  = 1'b1;
                sirq_out = 1'b0;
            end
            ST_DATA: begin
                if (phase == PH_SAMPLE && own_low) begin
                    sirq_oe  = 1'b1;
                    sirq_out = 1'b0;
                end else if (phase == PH_RECOVER && drove_low) begin
                    sirq_oe  = 1'b1;
                    sirq_out = 1'b1;
                end
            end
            default: begin
                sirq_oe  = 1'b0;
                sirq_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sirq_frame_engine_chk.sv
module sirq_frame_engine_chk
    import sirq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input sirq_state_t st,
    input sirq_phase_t ph,
    input logic        cont,
    input logic        oe,
    input logic        dout
);
    p_kick_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KICK) |-> (oe && !dout));

    p_kick_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KICK) |=> !oe);

    p_low_only_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !dout) |-> (st == ST_KICK || (st == ST_DATA && ph == PH_SAMPLE)));

    p_recover_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && ph == PH_RECOVER) |-> (oe == $past(oe && !dout)));

    p_high_only_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && dout) |-> (st == ST_DATA && ph == PH_RECOVER));

    p_turn_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && ph == PH_TURN) |-> !oe);

    p_cont_no_kick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && st == ST_IDLE) |=> (st != ST_KICK));

endmodule

bind sirq_frame_engine sirq_frame_engine_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .st   (state),
    .ph   (phase),
    .cont (cont_mode),
    .oe   (sirq_oe),
    .dout (sirq_out)
);

// File: tb/sirq_frame_engine_bench.sv
module sirq_frame_engine_bench;
    localparam int NL = 4;
    localparam int NF = 17;
    localparam int FW = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NL-1:0]   irq;
    logic [NL*FW-1:0] cfg;
    logic            host_oe, host_val;
    logic            sirq_oe, sirq_out;
    logic            wire_lvl;

    int     checks = 0;
    int     errors = 0;
    bit     quiet_model = 1'b1;
    logic [NL-1:0] rep = '1;

    always #4 clk = ~clk;

    assign wire_lvl = (host_oe ? host_val : 1'b1) & (sirq_oe ? sirq_out : 1'b1);

    sirq_frame_engine #(.NUM_LINES(NL), .NUM_FRAMES(NF)) u_sirq_frame_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_lines(irq),
        .frame_cfg(cfg),
        .sirq_in  (wire_lvl),
        .sirq_oe  (sirq_oe),
        .sirq_out (sirq_out)
    );

    function automatic int code_of(int i);
        return int'(cfg[i*FW +: FW]);
    endfunction

    function automatic bit pend();
        bit p = 1'b0;
        for (int i = 0; i < NL; i++)
            if (code_of(i) < NF && irq[i] != rep[i]) p = 1'b1;
        return p;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(bit oe, bit val);
        @(negedge clk);
        host_oe  = oe;
        host_val = val;
        #1;
    endtask

    task automatic host_cycle(bit self_start, int width, int idles, int stoplen,
                              int tog_line, int tog_frame);
        bit last_low = 1'b0;
        int nlow = self_start ? width - 1 : width;
        repeat (nlow) begin
            step(1'b1, 1'b0);
            chk(!sirq_oe, "R1", sirq_oe, 0);
        end
        step(1'b1, 1'b1);
        chk(!sirq_oe, "R6", sirq_oe, 0);
        step(1'b0, 1'b1);
        chk(!sirq_oe, "R6", sirq_oe, 0);
        for (int f = 0; f < NF; f++) begin
            for (int ph = 0; ph < 3; ph++) begin
                @(negedge clk);
                host_oe = 1'b0;
                if (ph == 0 && f == tog_frame) irq[tog_line] = ~irq[tog_line];
                #1;
                if (ph == 0) begin
                    bit exp_low = 1'b0;
                    for (int i = 0; i < NL; i++)
                        if (code_of(i) == f && !irq[i]) exp_low = 1'b1;
                    chk(sirq_oe == exp_low && wire_lvl == !exp_low, "R4",
                        {sirq_oe, wire_lvl}, {exp_low, !exp_low});
                    for (int i = 0; i < NL; i++)
                        if (code_of(i) == f) rep[i] = irq[i];
                    last_low = exp_low;
                end else if (ph == 1) begin
                    chk(sirq_oe == last_low && (!sirq_oe || sirq_out), "R5",
                        {sirq_oe, sirq_out}, {last_low, 1'b1});
                end else begin
                    chk(!sirq_oe, "R5", sirq_oe, 0);
                end
            end
        end
        repeat (idles) begin
            step(1'b0, 1'b1);
            chk(!sirq_oe, "R7", sirq_oe, 0);
        end
        repeat (stoplen) begin
            step(1'b1, 1'b0);
            chk(!sirq_oe, "R7", sirq_oe, 0);
        end
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        quiet_model = (stoplen == 2);
    endtask

    // After a stop: one idle clock, then the request decision clock.
    task automatic after_stop(int width);
        bit exp;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1);
            chk(!sirq_oe, "R2", sirq_oe, 0);
            step(1'b0, 1'b1);
            exp = quiet_model && pend();
            chk(sirq_oe == exp, exp ? "R2" : (quiet_model ? "R3" : "R8"), sirq_oe, exp);
            if (!exp) break;
            host_cycle(1'b1, width, 0, 2, 0, -1);
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL R4 watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit exp;
        rst_n   = 1'b0;
        irq     = '1;
        cfg     = '1;
        host_oe = 1'b0;
        host_val = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1);
        chk(!sirq_oe, "R10", sirq_oe, 0);
        // R9: changes on disabled lines (code 31) request nothing
        @(negedge clk); irq = 4'b0000; #1;
        repeat (3) begin
            step(1'b0, 1'b1);
            chk(!sirq_oe, "R9", sirq_oe, 0);
        end
        irq = '1;
        for (int r = 0; r < 40; r++) begin
            @(negedge clk);
            host_oe = 1'b0;
            for (int i = 0; i < NL; i++)
                cfg[i*FW +: FW] = FW'((r * 5 + i * 7 + r / 3) % 19);
            irq = NL'((r * 11 + 3) % 16);
            #1;
            chk(!sirq_oe, "R10", sirq_oe, 0);
            step(1'b0, 1'b1);
            exp = quiet_model && pend();
            chk(sirq_oe == exp && (wire_lvl == !exp), quiet_model ? "R1" : "R8",
                sirq_oe, exp);
            host_cycle(exp, 4 + r % 5, r % 3, (r % 3 == 2) ? 3 : 2,
                       r % NL, (r % 2 == 1) ? (r % NF) : -1);
            after_stop(4 + (r + 2) % 5);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule